// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is a synchronous burst memory with a two-stage read pipeline. It holds a small array of 18-bit words, each word split into two 9-bit byte lanes (eight data bits plus one parity bit per lane). Every command input is captured on the rising clock edge. A burst opens when either of two start strobes is sampled low, one meant for a processor and one for a cache controller. A gate built from three chip selects decides whether the burst is accepted. Once a burst is open, an advance input steps an internal 2-bit counter through four beats, in either linear or interleaved order. Holding the advance input high suspends the burst on its current word.

The two start strobes follow different write rules. A burst started by the processor strobe always reads on its first beat, and the write inputs are only looked at on later edges. A burst started by the controller strobe samples the write inputs on the start edge itself. A global write enable writes the whole word. Otherwise, a byte-write enable together with one enable per lane selects which lanes are written.

The bidirectional data bus is split into three signals: a data input, a data output and a drive enable. The drive enable is gated at once by the output enable and by the sleep input, and it drops for one cycle after any write edge. While sleep is high all state is frozen. After sleep falls, the block ignores all commands for two clock edges before it operates normally again.

Top module: `pbsram_ctrl`

## Requirements
- R1: The block is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. A start strobe accepted under any other combination ends the open burst and performs no access: no write takes place and no read data is driven.
- R2: When `start_cpu_n`=0 and `sel1_n`=0, a burst begins at `addr`, and this takes priority over `start_ctl_n`. When `sel1_n`=1, `start_cpu_n` is ignored and an open burst continues as if the strobe were high.
- R3: On an edge where the processor strobe starts a burst, `gwr_n`, `bwr_n` and `lane_wr_n` are ignored and the beat is a read. On the following edges of that burst, the write inputs are sampled.
- R4: `start_ctl_n`=0 starts a burst at `addr` only while `start_cpu_n`=1 (or `start_cpu_n` is ignored under R2). The write inputs are sampled on that same start edge.
- R5: The write decode works as follows. `gwr_n`=0 writes both lanes. With `gwr_n`=1 and `bwr_n`=0, each `lane_wr_n[i]`=0 writes lane i, where lane 0 is `din[8:0]` and lane 1 is `din[17:9]`. With `gwr_n`=1 and `bwr_n`=1, the beat is a read.
- R6: Inside a burst, `adv_n`=0 moves the 2-bit beat index to the next beat, and `adv_n`=1 repeats the current word. The word address is `addr[ADDR_W-1:2]` followed by low bits equal to base+index mod 4 when `order_ilv`=0, or base XOR index when `order_ilv`=1. Here base is `addr[1:0]` taken at the start edge.
- R7: A read accessed on rising edge k is shown on `dout`, with `dout_en`=1, after edge k+1. After reset, `dout_en` is 0.
- R8: After an edge on which a write was sampled, `dout_en` is 0 for the following cycle, whatever the value of `oe_n`.
- R9: `oe_n`=1 forces `dout_en` to 0 without waiting for a clock edge.
- R10: `sleep`=1 forces `dout_en` to 0 without waiting for a clock edge. While `sleep` is high, all internal state is kept and no write takes place.
- R11: After `sleep` falls, the first two rising edges ignore every command. A read that was pending when sleep began is still presented after the first of those edges.
- R12: A read issued on the edge before a deselect is still presented. `dout_en` is 0 from the second edge after the deselect onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address captured on a start edge |
| start_cpu_n | input | 1 | Processor burst-start strobe, active low |
| start_ctl_n | input | 1 | Controller burst-start strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high suspends the burst |
| sel1_n | input | 1 | Chip select, active low; also masks the processor strobe |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| gwr_n | input | 1 | Global write enable for the full word, active low |
| bwr_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data from the second pipeline stage |
| dout_en | output | 1 | Output drive enable for the data bus |

## Verification
The bench builds the block with `ADDR_W`=5, with 9-bit lanes and two lanes. This gives a 32-word array, made of eight four-word burst blocks. It can therefore fill every word with bursts that start at every possible low-address base, in both orders, and keep a complete reference copy of the whole array. With the wake delay left at two cycles, the bench can check the stale read that emerges on the first wake edge and the writes that are ignored on both wake edges. The small array also makes it cheap to prove that writes were ignored: after a suppressed write under deselect, sleep or the processor-start rule, the bench reads the affected word back.

// File: rtl/pbsram_pkg.sv
`timescale 1ns/1ps
package pbsram_pkg;

    // Kind of work performed on one rising edge
    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_DESEL,
        CYC_START_RD,
        CYC_START_CTL,
        CYC_CONT,
        CYC_SUSP
    } cyc_e;

    function automatic logic cyc_touches_array(cyc_e k);
        return (k == CYC_START_RD) || (k == CYC_START_CTL) ||
               (k == CYC_CONT)     || (k == CYC_SUSP);
    endfunction

    function automatic logic cyc_samples_write(cyc_e k);
        return (k == CYC_START_CTL) || (k == CYC_CONT) || (k == CYC_SUSP);
    endfunction

endpackage

// File: rtl/pbsram_burst_seq.sv
`timescale 1ns/1ps
module pbsram_burst_seq #(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] base,
    input  logic [CNT_W-1:0] step,
    input  logic             ilv,
    output logic [CNT_W-1:0] lo
);
    logic [CNT_W-1:0] lin_lo;
    logic [CNT_W-1:0] xor_lo;

    assign lin_lo = base + step;   // wraps within the burst block
    assign xor_lo = base ^ step;
    assign lo     = ilv ? xor_lo : lin_lo;
endmodule

// File: rtl/pbsram_wr_decode.sv
`timescale 1ns/1ps
module pbsram_wr_decode #(
    parameter int LANES = 2
) (
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic [LANES-1:0] mask
);
    always_comb begin
        if (!gwr_n)      mask = '1;
        else if (!bwr_n) mask = ~lane_wr_n;
        else             mask = '0;
    end
endmodule

// File: rtl/pbsram_array.sv
`timescale 1ns/1ps
module pbsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES-1:0]          we,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[addr];
    end
endmodule

// File: rtl/pbsram_ctrl.sv
`timescale 1ns/1ps
module pbsram_ctrl
    import pbsram_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int LANE_W   = 9,
    parameter int LANES    = 2,
    parameter int BURST_W  = 2,
    parameter int WAKE_CYC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    start_cpu_n,
    input  logic                    start_ctl_n,
    input  logic                    adv_n,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    gwr_n,
    input  logic                    bwr_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic                    order_ilv,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int HI_W   = ADDR_W - BURST_W;
    localparam int WAKE_W = $clog2(WAKE_CYC + 1);

    typedef struct packed {
        logic               active;
        logic [BURST_W-1:0] base;
        logic [BURST_W-1:0] step;
        logic [HI_W-1:0]    hi;
        logic               rd1;
        logic               rd2;
        logic               wr_now;
        logic [WAKE_W-1:0]  wake;
        logic [DATA_W-1:0]  q1;
        logic [DATA_W-1:0]  q2;
    } state_t;

    state_t s_q, s_d;

    cyc_e               kind;
    logic               sel_ok;
    logic               cpu_go;
    logic               ctl_go;
    logic               wake_busy;
    logic [BURST_W-1:0] base_n;
    logic [BURST_W-1:0] step_n;
    logic [HI_W-1:0]    hi_n;
    logic [BURST_W-1:0] seq_lo;
    logic [ADDR_W-1:0]  acc_addr;
    logic [LANES-1:0]   dec_mask;
    logic [LANES-1:0]   lane_we;
    logic [DATA_W-1:0]  rd_data;

    // Three-way select gate and strobe qualification
    assign sel_ok    = !sel1_n && sel2 && !sel3_n;
    assign cpu_go    = !start_cpu_n && !sel1_n;
    assign ctl_go    = !start_ctl_n && !cpu_go;
    assign wake_busy = (s_q.wake != '0);

    pbsram_wr_decode #(.LANES(LANES)) u_dec (
        .gwr_n     (gwr_n),
        .bwr_n     (bwr_n),
        .lane_wr_n (lane_wr_n),
        .mask      (dec_mask)
    );

    // Cycle classification and address selection
    always_comb begin
        kind   = CYC_IDLE;
        base_n = s_q.base;
        step_n = s_q.step;
        hi_n   = s_q.hi;
        if (!sleep && !wake_busy) begin
            if (cpu_go)        kind = sel_ok ? CYC_START_RD  : CYC_DESEL;
            else if (ctl_go)   kind = sel_ok ? CYC_START_CTL : CYC_DESEL;
            else if (s_q.active) kind = adv_n ? CYC_SUSP : CYC_CONT;
        end
        case (kind)
            CYC_START_RD, CYC_START_CTL: begin
                base_n = addr[BURST_W-1:0];
                step_n = '0;
                hi_n   = addr[ADDR_W-1:BURST_W];
            end
            CYC_CONT: step_n = s_q.step + BURST_W'(1);
            default: ;
        endcase
        lane_we = cyc_samples_write(kind) ? dec_mask : '0;
    end

    pbsram_burst_seq #(.CNT_W(BURST_W)) u_seq (
        .base (base_n),
        .step (step_n),
        .ilv  (order_ilv),
        .lo   (seq_lo)
    );

    assign acc_addr = {hi_n, seq_lo};

    pbsram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
        .clk   (clk),
        .addr  (acc_addr),
        .we    (lane_we),
        .wdata (din),
        .rdata (rd_data)
    );

    // Next-state computation
    always_comb begin
        s_d = s_q;
        if (sleep) begin
            s_d.wake = WAKE_W'(WAKE_CYC);
        end else begin
            if (wake_busy) s_d.wake = s_q.wake - WAKE_W'(1);
            if (kind == CYC_DESEL)
                s_d.active = 1'b0;
            else if (kind == CYC_START_RD || kind == CYC_START_CTL)
                s_d.active = 1'b1;
            s_d.base   = base_n;
            s_d.step   = step_n;
            s_d.hi     = hi_n;
            s_d.rd1    = cyc_touches_array(kind) && (lane_we == '0);
            s_d.rd2    = s_q.rd1;
            s_d.wr_now = |lane_we;
            s_d.q1     = rd_data;
            s_d.q2     = s_q.q1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout    = s_q.q2;
    assign dout_en = s_q.rd2 && !s_q.wr_now && !oe_n && !sleep;

endmodule

// File: rtl/pbsram_ctrl_chk.sv
`timescale 1ns/1ps
module pbsram_ctrl_chk #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_cpu_n,
    input logic             start_ctl_n,
    input logic             sel1_n,
    input logic             sel2,
    input logic             sel3_n,
    input logic             gwr_n,
    input logic             sleep,
    input logic             wake_busy,
    input logic [LANES-1:0] lane_we,
    input logic             dout_en
);
    // R1
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !wake_busy &&
         ((!start_cpu_n && !sel1_n) || !start_ctl_n) &&
         !(!sel1_n && sel2 && !sel3_n))
        |-> (lane_we == '0) ##2 !dout_en);

    // R3
    cpu_start_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !wake_busy && !start_cpu_n && !sel1_n) |-> (lane_we == '0));

    // R5
    global_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !wake_busy && start_cpu_n && !start_ctl_n &&
         !sel1_n && sel2 && !sel3_n && !gwr_n) |-> (lane_we == '1));

    // R8
    write_mutes_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we != '0) |=> !dout_en);

    // R10
    sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> ((lane_we == '0) && !dout_en));

    // R11
    wake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep) |-> (lane_we == '0) ##1 (lane_we == '0));
endmodule

bind pbsram_ctrl pbsram_ctrl_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_cpu_n (start_cpu_n),
    .start_ctl_n (start_ctl_n),
    .sel1_n      (sel1_n),
    .sel2        (sel2),
    .sel3_n      (sel3_n),
    .gwr_n       (gwr_n),
    .sleep       (sleep),
    .wake_busy   (wake_busy),
    .lane_we     (lane_we),
    .dout_en     (dout_en)
);

// File: tb/pbsram_ctrl_tb.sv
`timescale 1ns/1ps
module pbsram_ctrl_tb;
    localparam int AW = 5;
    localparam int DW = 18;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          start_cpu_n, start_ctl_n, adv_n;
    logic          sel1_n, sel2, sel3_n;
    logic          gwr_n, bwr_n;
    logic [1:0]    lane_wr_n;
    logic          oe_n, sleep, order_ilv;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_en;

    logic [DW-1:0] ref_mem [NW];
    int            n_chk  = 0;
    int            n_fail = 0;

    always #2.5 clk = ~clk;

    pbsram_ctrl #(.ADDR_W(AW), .LANE_W(9), .LANES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n), .adv_n(adv_n),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_wr_n(lane_wr_n),
        .oe_n(oe_n), .sleep(sleep), .order_ilv(order_ilv),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        start_cpu_n = 1'b1; start_ctl_n = 1'b1; adv_n = 1'b1;
        sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
        gwr_n = 1'b1; bwr_n = 1'b1; lane_wr_n = 2'b11;
        din = '0; addr = '0;
    endtask

    function automatic logic [1:0] exp_lo(input logic [1:0] b, input int i, input logic ilv);
        logic [1:0] s = 2'(i);
        return ilv ? (b ^ s) : (b + s);
    endfunction

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] a, input int i, input logic ilv);
        return {a[AW-1:2], exp_lo(a[1:0], i, ilv)};
    endfunction

    task automatic desel();
        idle(); start_cpu_n = 1'b0; sel2 = 1'b0; tick();
        idle(); tick(); tick();
    endtask

    task automatic wr_burst(input logic [AW-1:0] a, input logic ilv, input logic [DW-1:0] seed);
        order_ilv = ilv;
        for (int i = 0; i < 4; i++) begin
            idle();
            if (i == 0) begin start_ctl_n = 1'b0; addr = a; end
            else adv_n = 1'b0;
            gwr_n = 1'b0;
            din = seed + DW'(i * 37);
            ref_mem[beat_addr(a, i, ilv)] = din;
            tick();
        end
        desel();
    endtask

    task automatic rd_burst(input logic [AW-1:0] a, input logic ilv, input string tag);
        order_ilv = ilv;
        idle(); start_cpu_n = 1'b0; addr = a; tick();
        for (int i = 1; i <= 4; i++) begin
            idle();
            if (i < 4) adv_n = 1'b0;
            tick();
            check({tag, " R7 drive"}, 32'(dout_en), 32'd1);
            check({tag, " R6 data"}, 32'(dout), 32'(ref_mem[beat_addr(a, i - 1, ilv)]));
        end
        desel();
    endtask

    task automatic rd_single(input logic [AW-1:0] a, input string tag);
        idle(); start_cpu_n = 1'b0; addr = a; tick();
        idle(); tick();
        check(tag, 32'(dout), 32'(ref_mem[a]));
        desel();
    endtask

    // R7: reset state
    task automatic t_reset();
        check("R7 reset drive", 32'(dout_en), 32'd0);
    endtask

    // R4 R6 R7: fill by controller bursts, read by processor bursts
    task automatic t_fill_and_read();
        for (int b = 0; b < NW / 4; b++)
            wr_burst(AW'(b * 4 + (b % 4)), 1'(b % 2), DW'(18'h1A5 * (b + 1)));
        rd_burst(5'h00, 1'b0, "lin base0");
        rd_burst(5'h07, 1'b0, "lin base3");
        rd_burst(5'h0A, 1'b1, "ilv base2");
        rd_burst(5'h1D, 1'b1, "ilv base1");
        rd_burst(5'h16, 1'b0, "lin base2");
    endtask

    // R5: byte-lane and global write decode
    task automatic t_lanes();
        logic [AW-1:0] a = 5'h09;
        idle(); start_ctl_n = 1'b0; addr = a; bwr_n = 1'b0; lane_wr_n = 2'b10;
        din = 18'h2A_B5C; tick();
        ref_mem[a][8:0] = 9'h15C;
        desel();
        rd_single(a, "R5 lane0 only");
        idle(); start_ctl_n = 1'b0; addr = a; bwr_n = 1'b0; lane_wr_n = 2'b01;
        din = 18'h1F_E03; tick();
        ref_mem[a][17:9] = 9'h0FF;
        desel();
        rd_single(a, "R5 lane1 only");
        // gwr high, bwr high, lanes low: read beat
        idle(); start_ctl_n = 1'b0; addr = a; lane_wr_n = 2'b00; din = 18'h3FFFF; tick();
        idle(); tick();
        check("R5 no-write read", 32'(dout), 32'(ref_mem[a]));
        check("R5 no-write drive", 32'(dout_en), 32'd1);
        desel();
        // global write overrides bwr and lanes
        idle(); start_ctl_n = 1'b0; addr = a; gwr_n = 1'b0; bwr_n = 1'b1; lane_wr_n = 2'b11;
        din = 18'h0_BEEF; tick();
        ref_mem[a] = 18'h0_BEEF;
        desel();
        rd_single(a, "R5 global write");
    endtask

    // R3: processor start ignores write inputs, later edges sample them
    task automatic t_cpu_start_read();
        logic [AW-1:0] a = 5'h14;
        order_ilv = 1'b0;
        idle(); start_cpu_n = 1'b0; addr = a; gwr_n = 1'b0; din = 18'h33333; tick();
        idle(); tick();
        check("R3 first beat read", 32'(dout), 32'(ref_mem[a]));
        idle(); adv_n = 1'b0; gwr_n = 1'b0; din = 18'h0C0DE; tick();
        ref_mem[5'h15] = 18'h0C0DE;
        desel();
        rd_single(a, "R3 start word untouched");
        rd_single(5'h15, "R3 later edge writes");
    endtask

    // R2: strobe priority and masking by sel1_n
    task automatic t_cpu_strobe();
        order_ilv = 1'b0;
        idle(); start_cpu_n = 1'b0; addr = 5'h18; tick();
        idle(); adv_n = 1'b0; start_cpu_n = 1'b0; sel1_n = 1'b1; addr = 5'h03; tick();
        check("R2 beat0", 32'(dout), 32'(ref_mem[5'h18]));
        idle(); tick();
        check("R2 masked strobe keeps burst", 32'(dout), 32'(ref_mem[5'h19]));
        desel();
        idle(); start_cpu_n = 1'b0; start_ctl_n = 1'b0; gwr_n = 1'b0; addr = 5'h05;
        din = 18'h2DEAD; tick();
        idle(); tick();
        check("R2 processor wins", 32'(dout), 32'(ref_mem[5'h05]));
        desel();
        rd_single(5'h05, "R2 controller write dropped");
    endtask

    // R6: suspend repeats the current word
    task automatic t_suspend();
        order_ilv = 1'b0;
        idle(); start_cpu_n = 1'b0; addr = 5'h0D; tick();
        idle(); tick();
        check("R6 suspend beat0", 32'(dout), 32'(ref_mem[5'h0D]));
        idle(); adv_n = 1'b0; tick();
        check("R6 suspend repeat", 32'(dout), 32'(ref_mem[5'h0D]));
        idle(); tick();
        check("R6 after suspend", 32'(dout), 32'(ref_mem[5'h0E]));
        desel();
    endtask

    // R1 R12: select gate and pipeline drain
    task automatic t_select();
        for (int c = 0; c < 3; c++) begin
            idle(); start_cpu_n = 1'b0; addr = 5'h02;
            if (c == 0) sel2 = 1'b0;
            if (c == 1) sel3_n = 1'b1;
            if (c == 2) begin start_cpu_n = 1'b1; start_ctl_n = 1'b0; sel1_n = 1'b1; end
            tick();
            idle(); tick(); tick();
            check($sformatf("R1 bad select %0d no drive", c), 32'(dout_en), 32'd0);
        end
        idle(); start_ctl_n = 1'b0; addr = 5'h02; sel3_n = 1'b1; gwr_n = 1'b0; din = 18'h11111; tick();
        desel();
        rd_single(5'h02, "R1 deselected write dropped");
        idle(); start_cpu_n = 1'b0; addr = 5'h1E; tick();
        idle(); start_cpu_n = 1'b0; sel2 = 1'b0; tick();
        check("R12 pending read drive", 32'(dout_en), 32'd1);
        check("R12 pending read data", 32'(dout), 32'(ref_mem[5'h1E]));
        idle(); tick();
        check("R12 drained", 32'(dout_en), 32'd0);
        idle(); tick();
        check("R12 stays off", 32'(dout_en), 32'd0);
    endtask

    // R8: a write edge mutes the bus for a cycle
    task automatic t_write_mute();
        order_ilv = 1'b0;
        idle(); start_cpu_n = 1'b0; addr = 5'h10; tick();
        idle(); adv_n = 1'b0; gwr_n = 1'b0; din = 18'h2468A; tick();
        ref_mem[5'h11] = 18'h2468A;
        check("R8 muted after write", 32'(dout_en), 32'd0);
        desel();
        rd_single(5'h11, "R8 write landed");
    endtask

    // R9: asynchronous output enable
    task automatic t_oe();
        idle(); start_cpu_n = 1'b0; addr = 5'h08; tick();
        idle(); tick();
        check("R9 driving", 32'(dout_en), 32'd1);
        oe_n = 1'b1; #1;
        check("R9 oe high mutes", 32'(dout_en), 32'd0);
        oe_n = 1'b0; #1;
        check("R9 oe low restores", 32'(dout_en), 32'd1);
        desel();
    endtask

    // R10 R11: sleep freeze and wake delay
    task automatic t_sleep();
        logic [AW-1:0] a = 5'h0C;
        idle(); start_cpu_n = 1'b0; addr = a; tick();
        idle(); tick();
        check("R10 drive before sleep", 32'(dout_en), 32'd1);
        sleep = 1'b1; #1;
        check("R10 sleep mutes at once", 32'(dout_en), 32'd0);
        for (int i = 0; i < 3; i++) begin
            idle(); start_ctl_n = 1'b0; addr = a; gwr_n = 1'b0; din = 18'h3C3C3; tick();
            check("R10 quiet while asleep", 32'(dout_en), 32'd0);
        end
        sleep = 1'b0;
        idle(); start_ctl_n = 1'b0; addr = a; gwr_n = 1'b0; din = 18'h15151; tick();
        check("R11 kept read shown drive", 32'(dout_en), 32'd1);
        check("R11 kept read shown data", 32'(dout), 32'(ref_mem[a]));
        idle(); start_ctl_n = 1'b0; addr = a; gwr_n = 1'b0; din = 18'h15151; tick();
        check("R11 second wake edge idle", 32'(dout_en), 32'd0);
        rd_single(a, "R11 R10 no write during sleep or wake");
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; oe_n = 1'b0; sleep = 1'b0; order_ilv = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_and_read();
        t_lanes();
        t_cpu_start_read();
        t_cpu_strobe();
        t_suspend();
        t_select();
        t_write_mute();
        t_oe();
        t_sleep();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule